// File: doc/BRIEF.md
# Scaled 64-bit system counter

This block keeps a free-running 64-bit count that advances on a tick-enable input. Software reaches it through a small 32-bit register bus. That bus holds:

- a control word with two enables, one for counting and one for scaling;
- a status word;
- the count, split into a low word and a high word;
- a scale word.

With scaling off, every tick adds one to the count. With scaling on, every tick adds an unsigned fixed-point increment taken from the scale word. The increment has 24 fractional bits, so the counter can run at a fraction of the tick rate, or at a multiple of it.

The count is held inside an 88-bit accumulator: 64 integer bits above 24 fractional bits. Reads of the count words return only the integer part. Writing either count word presets that half of the integer part and discards any accumulated fraction.

The full 64-bit value is updated in one register transfer. A carry into the high word therefore becomes visible in the same cycle as the low-word change. The count wraps modulo 2^64.

Top module: `sysctr_top`

## Requirements
- R1: After reset, the registers read as follows: control (offset 0x0) reads 0, status (0x4) reads 0x2, count low (0x8) and count high (0xC) read 0, and scale (0x10) reads 0x01000000.
- R2: While control bit 0 (count enable) is clear, ticks leave the count unchanged, whatever the state of control bit 2 (scale enable).
- R3: With bit 0 set and bit 2 clear, each clock cycle with tick high adds exactly one to the count.
- R4: With bits 0 and 2 both set, each tick adds the scale value to the accumulator. The scale value is unsigned, with bits 23:0 fractional. Reads return only the integer part. For example, 160 ticks at 0x00100000 take a count of 100 to 110.
- R5: A write to offset 0x8 or 0xC replaces that 32-bit half of the integer count and clears the fractional part. The new value is readable from the next cycle.
- R6: Status bit 1 reads 1 exactly when control bit 0 is clear. All other status bits read 0.
- R7: The count wraps modulo 2^64, and a carry from the low word into the high word appears in the same cycle as the low-word change.
- R8: Any offset other than the five listed, including unaligned ones, reads 0, and writes to it change no register. Control bits other than 0 and 2 read 0.
- R9: A scale write in the same cycle as a tick does not affect that tick. The new scale applies from the following tick.
- R10: A count-word write in the same cycle as a tick takes priority: the written value is loaded and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Advance the counter this cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while a read is selected, otherwise 0 |

## Verification
The properties assume that a bus access lasts exactly one cycle with a fixed address. They also assume that the tick is sampled only at rising edges, so tick and bus inputs are stable around each edge. The bench meets this by changing every input on the falling edge and sampling read data a moment later in that same low phase.

The bench stays inside the internal reset's release window by waiting several cycles after reset before any access. Wrap and carry cases are reached by presetting the count through its own words rather than by ticking for 2^64 cycles.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 64;
  localparam int FRAC_W  = 24;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SCALE  = 8'h10;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SCL_BIT  = 2;
  localparam int STAT_HALT_BIT = 1;

  localparam logic [DATA_W-1:0] SCALE_RESET = 32'h0100_0000;
endpackage

// File: rtl/sysctr_rst_sync.sv
module sysctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sysctr_regs.sv
module sysctr_regs
  import sysctr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          en,
  output logic          scl_en,
  output logic [DW-1:0] scale,
  output logic          lo_wr,
  output logic          hi_wr
);
  logic          wr_acc;
  logic          ctrl_wr;
  logic          scale_wr;
  logic          en_d, en_q;
  logic          scl_d, scl_q;
  logic [DW-1:0] scale_d, scale_q;

  // address decode of writes
  always_comb begin
    wr_acc   = bus_sel && bus_wr;
    ctrl_wr  = wr_acc && (bus_addr == AW'(OFF_CTRL));
    scale_wr = wr_acc && (bus_addr == AW'(OFF_SCALE));
    lo_wr    = wr_acc && (bus_addr == AW'(OFF_CNT_LO));
    hi_wr    = wr_acc && (bus_addr == AW'(OFF_CNT_HI));
  end

  // next state
  always_comb begin
    en_d    = en_q;
    scl_d   = scl_q;
    scale_d = scale_q;
    if (ctrl_wr) begin
      en_d  = bus_wdata[CTRL_EN_BIT];
      scl_d = bus_wdata[CTRL_SCL_BIT];
    end
    if (scale_wr) begin
      scale_d = bus_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      scl_q   <= 1'b0;
      scale_q <= DW'(SCALE_RESET);
    end else begin
      if (ctrl_wr) begin
        en_q  <= en_d;
        scl_q <= scl_d;
      end
      if (scale_wr) begin
        scale_q <= scale_d;
      end
    end
  end

  assign en     = en_q;
  assign scl_en = scl_q;
  assign scale  = scale_q;
endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum
  import sysctr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int FW = FRAC_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          scl_en,
  input  logic [DW-1:0] scale,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] count
);
  localparam int ACC_W = CW + FW;
  localparam int HI_W  = CW - DW;
  localparam logic [ACC_W-1:0] ONE_CNT = ACC_W'(1) << FW;

  logic [ACC_W-1:0] acc_q, acc_d, inc;
  logic             acc_ce;
  logic [CW-1:0]    int_q;

  assign int_q = acc_q[ACC_W-1:FW];

  always_comb begin
    if (scl_en) inc = {{(ACC_W-DW){1'b0}}, scale};
    else        inc = ONE_CNT;
  end

  // next state: a count write beats a tick in the same cycle
  always_comb begin
    acc_d  = acc_q;
    acc_ce = 1'b0;
    if (lo_wr) begin
      acc_d  = {int_q[CW-1:DW], wdata, {FW{1'b0}}};
      acc_ce = 1'b1;
    end else if (hi_wr) begin
      acc_d  = {wdata[HI_W-1:0], int_q[DW-1:0], {FW{1'b0}}};
      acc_ce = 1'b1;
    end else if (tick && en) begin
      acc_d  = acc_q + inc;
      acc_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign count = int_q;
endmodule

// File: rtl/sysctr_rdmux.sv
module sysctr_rdmux
  import sysctr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic          en,
  input  logic          scl_en,
  input  logic [DW-1:0] scale,
  input  logic [CW-1:0] count,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ctrl_word, stat_word;

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[CTRL_EN_BIT]  = en;
    ctrl_word[CTRL_SCL_BIT] = scl_en;
    stat_word                = '0;
    stat_word[STAT_HALT_BIT] = ~en;
  end

  always_comb begin
    rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFF_CTRL):   rdata = ctrl_word;
        AW'(OFF_STAT):   rdata = stat_word;
        AW'(OFF_CNT_LO): rdata = count[DW-1:0];
        AW'(OFF_CNT_HI): rdata = count[CW-1:DW];
        AW'(OFF_SCALE):  rdata = scale;
        default:         rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              rst_n_s;
  logic              en, scl_en;
  logic [DATA_W-1:0] scale;
  logic              lo_wr, hi_wr, cnt_wr;
  logic [CNT_W-1:0]  count;

  assign cnt_wr = lo_wr | hi_wr;

  sysctr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sysctr_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en(en), .scl_en(scl_en),
    .scale(scale), .lo_wr(lo_wr), .hi_wr(hi_wr)
  );

  sysctr_accum #(.CW(CNT_W), .FW(FRAC_W), .DW(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .en(en), .scl_en(scl_en),
    .scale(scale), .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(bus_wdata),
    .count(count)
  );

  sysctr_rdmux #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_rd (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .en(en),
    .scl_en(scl_en), .scale(scale), .count(count), .rdata(bus_rdata)
  );
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
  import sysctr_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              tick,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              en,
  input logic              scl_en,
  input logic              lo_wr,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  count
);
  logic rd_acc, mapped;
  assign rd_acc = bus_sel && !bus_wr;
  assign mapped = (bus_addr == OFF_CTRL) || (bus_addr == OFF_STAT) ||
                  (bus_addr == OFF_CNT_LO) || (bus_addr == OFF_CNT_HI) ||
                  (bus_addr == OFF_SCALE);

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!en && !cnt_wr) |=> $stable(count));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en && !scl_en && tick && !cnt_wr) |=> (count == $past(count) + 64'd1));

  // R5
  preset_lo_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lo_wr |=> (count[DATA_W-1:0] == $past(bus_wdata)));

  // R6
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_acc && bus_addr == OFF_STAT) |-> (bus_rdata == {30'd0, !en, 1'b0}));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en && !scl_en && tick && !cnt_wr && count == '1) |=> (count == '0));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_acc && !mapped) |-> (bus_rdata == '0));
endmodule

bind sysctr_top sysctr_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .tick(tick), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .en(en), .scl_en(scl_en), .lo_wr(lo_wr),
  .cnt_wr(cnt_wr), .count(count)
);

// File: tb/tb_sysctr_top.sv
`timescale 1ns/100ps
module tb_sysctr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctr_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] scale;
    logic [63:0] preset;
    logic [15:0] ticks;
    logic [63:0] expect_cnt;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'd1, 32'h0100_0000, 64'd0,                  16'd100, 64'd100},          // R3
    '{32'd5, 32'h0010_0000, 64'd100,                16'd160, 64'd110},          // R4
    '{32'd5, 32'h0280_0000, 64'd0,                  16'd10,  64'd25},           // R4
    '{32'd4, 32'h0100_0000, 64'd7,                  16'd20,  64'd7},            // R2
    '{32'd1, 32'h0100_0000, 64'hFFFF_FFFF_FFFF_FFFE, 16'd3,  64'd1},            // R7
    '{32'd1, 32'h0100_0000, 64'h0000_0000_FFFF_FFFF, 16'd1,  64'h1_0000_0000},  // R7
    '{32'd5, 32'h00C0_0000, 64'd0,                  16'd4,   64'd3}             // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(8'h08, lo);
    rd(8'h0C, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic preset(input logic [63:0] v);
    wr(8'h08, v[31:0]);
    wr(8'h0C, v[63:32]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(8'h00, r); chk("R1 ctrl", 64'(r), 64'd0);
    rd(8'h04, r); chk("R1 status", 64'(r), 64'd2);
    rd64(c);      chk("R1 count", c, 64'd0);
    rd(8'h10, r); chk("R1 scale", 64'(r), 64'h0100_0000);

    // R2 ticks while disabled
    ticks(50);
    rd64(c); chk("R2 disabled", c, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(8'h00, 32'd0);
      wr(8'h10, VECS[i].scale);
      preset(VECS[i].preset);
      wr(8'h00, VECS[i].ctrl);
      ticks(int'(VECS[i].ticks));
      wr(8'h00, 32'd0);
      rd64(c);
      chk($sformatf("R2/R3/R4/R7 vector %0d", i), c, VECS[i].expect_cnt);
    end

    // R6 status follows enable
    wr(8'h00, 32'd1);
    rd(8'h04, r); chk("R6 status enabled", 64'(r), 64'd0);
    wr(8'h00, 32'd0);
    rd(8'h04, r); chk("R6 status halted", 64'(r), 64'd2);

    // R8 reserved control bits and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, r); chk("R8 reserved ctrl bits", 64'(r), 64'd5);
    wr(8'h00, 32'd0);
    wr(8'h10, 32'h0100_0000);
    preset(64'd42);
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h09, 32'h1234_5678);
    wr(8'h11, 32'h0);
    rd(8'h14, r); chk("R8 unmapped read", 64'(r), 64'd0);
    rd(8'h09, r); chk("R8 unaligned read", 64'(r), 64'd0);
    rd64(c);      chk("R8 count untouched", c, 64'd42);
    rd(8'h10, r); chk("R8 scale untouched", 64'(r), 64'h0100_0000);
    rd(8'h00, r); chk("R8 ctrl untouched", 64'(r), 64'd0);

    // R5 preset clears fraction
    wr(8'h10, 32'h0080_0000);
    preset(64'd0);
    wr(8'h00, 32'd5);
    ticks(1);
    wr(8'h08, 32'd5);
    ticks(1);
    wr(8'h00, 32'd0);
    rd64(c); chk("R5 fraction cleared", c, 64'd5);
    wr(8'h0C, 32'hA5A5_0001);
    rd64(c); chk("R5 high preset", c, 64'hA5A5_0001_0000_0005);

    // R9 scale write with tick uses old scale
    wr(8'h10, 32'h0100_0000);
    preset(64'd0);
    wr(8'h00, 32'd5);
    wr_tick(8'h10, 32'h0200_0000);
    ticks(1);
    wr(8'h00, 32'd0);
    rd64(c); chk("R9 scale next tick", c, 64'd3);

    // R10 count write wins over tick
    preset(64'd0);
    wr(8'h00, 32'd1);
    wr_tick(8'h08, 32'd9);
    wr(8'h00, 32'd0);
    rd64(c); chk("R10 write beats tick", c, 64'd9);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule